// File: doc/BRIEF.md
# PWM Shared Phase Timer

This block is the common timebase for a bank of pulse-width modulators. It keeps one 16-bit fractional phase value that all channel comparators share, so every channel's pulses line up in time. A divider cuts the core clock into beats. On each beat the phase moves forward by a step that a resolution setting chooses. A coarser resolution gives fewer beats per pulse cycle and so a faster pulse rate.

Software, or the logic in front of this block, sets the divider and resolution while the counter is stopped, then raises the enable. While the enable is high, the captured settings stay fixed. Along with the phase, the block gives two one-clock strobes. One marks each beat end. The other marks the beat after which the phase wraps back to zero, which is where a new pulse cycle starts.

Top module: `pwm_phase_timer`

## Requirements
- R1: The phase output changes only on a clock edge at which beat_end_o is high, and it advances modulo 65536.
- R2: On each beat the phase grows by 2^(15 - res), where res is the captured resolution. A resolution of 15 gives a step of 1, a resolution of 0 gives a step of 32768, and one pulse cycle holds 2^(res+1) beats.
- R3: beat_end_o is high for one clock out of every div+1 clocks, where div is the captured divider value. It rises on the clock in which the internal divider count, running 0 to div, equals div.
- R4: cycle_end_o is high only together with beat_end_o, on exactly the beat whose step carries the phase past 65535. In the next clock the phase reads 0.
- R5: While cnt_en is low, the phase reads 0 and both strobes are low.
- R6: The divider and resolution inputs are captured only on edges where cnt_en is low. Changes made while cnt_en is high have no effect on the beat spacing or the step.
- R7: Let cnt_en be sampled high first at edge E. In the clock after E, the phase is 0 and the divider count is 0, and beat_end_o is high in that clock only if div is 0. The first step of the phase happens at edge E+div+1.
- R8: A synchronous active-high reset clears the phase, the divider count, the captured settings and both strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counter enable; low holds everything at zero and opens configuration capture |
| div_cfg | input | 16 | Beat length minus one, in core clocks |
| res_cfg | input | 4 | Resolution; step per beat is 2^(15 - res_cfg) |
| phase_o | output | 16 | Shared phase value |
| beat_end_o | output | 1 | One-clock strobe on the last clock of each beat |
| cycle_end_o | output | 1 | One-clock strobe on the beat whose step wraps the phase to zero |

## Verification
The beat strobe and the cycle-end strobe coincide on every wrapping beat. With a divider of zero, a beat ends in every clock, so the wrap beat also meets the first beat after enable and the clearing on disable. Vectors with a divider of zero and a resolution of 0 or 1 wrap within two to four beats, and the bench predicts phase and both strobes for every clock from the clock count since enable. The bench also changes the configuration in the middle of a run and confirms that the old spacing and step continue.

// File: rtl/pwm_phase_pkg.sv
package pwm_phase_pkg;

    localparam int PH_W  = 16;
    localparam int DIV_W = 16;
    localparam int RES_W = $clog2(PH_W);

    typedef logic [PH_W-1:0]  phase_t;
    typedef logic [DIV_W-1:0] div_t;
    typedef logic [RES_W-1:0] res_t;

    // configuration frozen while the counter runs
    typedef struct packed {
        div_t div;
        res_t res;
    } tcfg_t;

    // phase increment for a resolution setting: 2^(PH_W-1-res)
    function automatic phase_t step_of(res_t r);
        phase_t s;
        s = '0;
        s[PH_W-1-int'(r)] = 1'b1;
        return s;
    endfunction

endpackage

// File: rtl/pwm_cfg_capture.sv
module pwm_cfg_capture
    import pwm_phase_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cnt_en,
    input  div_t  div_i,
    input  res_t  res_i,
    output tcfg_t cfg_q,
    output logic  run_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            run_q <= 1'b0;
        end else begin
            run_q <= cnt_en;
            if (!cnt_en) begin
                cfg_q.div <= div_i;
                cfg_q.res <= res_i;
            end
        end
    end

endmodule

// File: rtl/pwm_beat_divider.sv
module pwm_beat_divider
    import pwm_phase_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cnt_en,
    input  logic run,
    input  div_t lim,
    output logic beat
);

    div_t cnt_q;
    logic at_lim;

    assign at_lim = (cnt_q == lim);
    assign beat   = run && cnt_en && at_lim;

    always_ff @(posedge clk) begin
        if (rst || !cnt_en) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= at_lim ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_phase_accum.sv
module pwm_phase_accum
    import pwm_phase_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cnt_en,
    input  logic   beat,
    input  res_t   res,
    output phase_t phase,
    output logic   wrap
);

    phase_t nxt;
    logic   carry;

    assign {carry, nxt} = {1'b0, phase} + {1'b0, step_of(res)};
    assign wrap = beat && carry;

    always_ff @(posedge clk) begin
        if (rst || !cnt_en) begin
            phase <= '0;
        end else if (beat) begin
            phase <= nxt;
        end
    end

endmodule

// File: rtl/pwm_phase_timer.sv
module pwm_phase_timer
    import pwm_phase_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cnt_en,
    input  logic [15:0] div_cfg,
    input  logic [3:0]  res_cfg,
    output logic [15:0] phase_o,
    output logic        beat_end_o,
    output logic        cycle_end_o
);

    tcfg_t  cfg_q;
    logic   run_q;
    logic   beat;
    logic   wrap;
    phase_t phase;

    pwm_cfg_capture u_cap (
        .clk    (clk),
        .rst    (rst),
        .cnt_en (cnt_en),
        .div_i  (div_t'(div_cfg)),
        .res_i  (res_t'(res_cfg)),
        .cfg_q  (cfg_q),
        .run_q  (run_q)
    );

    pwm_beat_divider u_div (
        .clk    (clk),
        .rst    (rst),
        .cnt_en (cnt_en),
        .run    (run_q),
        .lim    (cfg_q.div),
        .beat   (beat)
    );

    pwm_phase_accum u_acc (
        .clk    (clk),
        .rst    (rst),
        .cnt_en (cnt_en),
        .beat   (beat),
        .res    (cfg_q.res),
        .phase  (phase),
        .wrap   (wrap)
    );

    assign phase_o     = phase;
    assign beat_end_o  = beat;
    assign cycle_end_o = wrap;

endmodule

// File: rtl/pwm_phase_timer_chk.sv
module pwm_phase_timer_chk
    import pwm_phase_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        cnt_en,
    input logic [15:0] phase_o,
    input logic        beat_end_o,
    input logic        cycle_end_o,
    input div_t        cap_div,
    input res_t        cap_res
);

    AST_STILL_OFF_BEAT: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !beat_end_o) |=> $stable(phase_o)); // R1

    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && beat_end_o) |=> (phase_o == phase_t'($past(phase_o) + step_of($past(cap_res))))); // R2

    AST_WRAP_ON_BEAT: assert property (@(posedge clk) disable iff (rst)
        cycle_end_o |-> beat_end_o); // R4

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        cycle_end_o |=> (phase_o == '0)); // R4

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |-> (!beat_end_o && !cycle_end_o)); // R5

    AST_OFF_ZERO: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> (phase_o == '0)); // R5

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        cnt_en |=> ($stable(cap_div) && $stable(cap_res))); // R6

endmodule

bind pwm_phase_timer pwm_phase_timer_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cnt_en      (cnt_en),
    .phase_o     (phase_o),
    .beat_end_o  (beat_end_o),
    .cycle_end_o (cycle_end_o),
    .cap_div     (cfg_q.div),
    .cap_res     (cfg_q.res)
);

// File: tb/pwm_phase_timer_test.sv
module pwm_phase_timer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_en = 1'b0;
    logic [15:0] div_cfg = '0;
    logic [3:0]  res_cfg = '0;
    logic [15:0] phase_o;
    logic        beat_end_o;
    logic        cycle_end_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    pwm_phase_timer uut (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .div_cfg(div_cfg),
        .res_cfg(res_cfg), .phase_o(phase_o), .beat_end_o(beat_end_o),
        .cycle_end_o(cycle_end_o)
    );

    localparam int NV = 7;
    localparam logic [15:0] V_DIV [NV] = '{16'd0, 16'd0, 16'd2, 16'd0, 16'd1, 16'd4, 16'd0};
    localparam logic [3:0]  V_RES [NV] = '{4'd0, 4'd1, 4'd3, 4'd15, 4'd1, 4'd2, 4'd14};
    localparam int          V_LEN [NV] = '{8, 12, 60, 20, 24, 70, 16};

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // k = clocks since enable first sampled high (0 = first clock after that edge)
    task automatic check_at(int k, longint d, longint r);
        longint step, b, m, ph, nx;
        step = longint'(1) << (15 - r);
        b  = k / (d + 1);
        m  = k % (d + 1);
        ph = (b * step) % 65536;
        nx = ((b + 1) * step) % 65536;
        chk("R1/R2 phase", phase_o, ph);
        chk("R3 beat_end", beat_end_o, (m == d));
        chk("R4 cycle_end", cycle_end_o, (m == d) && (nx == 0));
    endtask

    task automatic load_cfg(logic [15:0] d, logic [3:0] r);
        @(negedge clk);
        cnt_en = 1'b0; div_cfg = d; res_cfg = r;
        @(negedge clk);
        chk("R5 phase off", phase_o, 0);
        chk("R5 beat off", beat_end_o, 0);
        chk("R5 cycle off", cycle_end_o, 0);
    endtask

    task automatic run_vec(logic [15:0] d, logic [3:0] r, int n);
        load_cfg(d, r);
        cnt_en = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (k == 0) begin
                chk("R7 start phase", phase_o, 0);
                chk("R7 start beat", beat_end_o, (d == 0));
            end
            check_at(k, d, r);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: outputs during reset, even with enable high
        cnt_en = 1'b1; div_cfg = 16'd3; res_cfg = 4'd5;
        @(negedge clk);
        chk("R8 phase in reset", phase_o, 0);
        chk("R8 beat in reset", beat_end_o, 0);
        chk("R8 cycle in reset", cycle_end_o, 0);
        cnt_en = 1'b0;
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) run_vec(V_DIV[i], V_RES[i], V_LEN[i]);

        // R6: change settings mid-run, the old spacing and step must remain
        load_cfg(16'd1, 4'd13);
        cnt_en = 1'b1;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            check_at(k, 1, 13);
            if (k == 5) begin div_cfg = 16'd6; res_cfg = 4'd0; end
        end

        // R5: drop enable, outputs clear and stay clear
        @(negedge clk);
        cnt_en = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R5 phase held", phase_o, 0);
            chk("R5 beat held", beat_end_o, 0);
            chk("R5 cycle held", cycle_end_o, 0);
        end

        // R6: the values set mid-run are captured once disabled
        cnt_en = 1'b1;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            check_at(k, 6, 0);
        end

        // R8: reset during a run clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R8 phase after reset", phase_o, 0);
        chk("R8 beat after reset", beat_end_o, 0);
        chk("R8 cycle after reset", cycle_end_o, 0);
        rst = 1'b0; cnt_en = 1'b0;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule